// File: doc/BRIEF.md
# Firmware Glue Register Block

This block is a small memory-mapped slave that gives boot firmware a handful of system-level controls. A processor can request a halt with an 8-bit exit code, learn its own index, learn how many processors the system was built with, and drive a level onto the external interrupt line of any processor.

Requests arrive on a simple bus carrying a valid strobe, a write flag, an address, an access size in bytes and 32 bits of write data. Only the low six address bits are decoded, so the register window repeats every 64 bytes. A requester-ID input tells the block which processor issued the access.

Each access passes through a three-state controller:

- **ST_IDLE** waits with `bus_ready` high. A valid request is captured on the clock edge and moves the controller to ST_READ (transition *accept_read*) or ST_WRITE (transition *accept_write*).
- **ST_READ** computes the zero-filled read word. On the next edge the word lands in `bus_rdata` with a one-cycle `bus_rvalid`, and the controller returns to ST_IDLE (transition *read_done*).
- **ST_WRITE** applies the effect of the write on the next edge (a halt pulse, an interrupt update, or nothing) and returns to ST_IDLE (transition *write_done*).

An access therefore takes two clock edges, and `bus_ready` is low for the one cycle between them.

Top module: `glue_fw_regs`

## Requirements
- R1: Only address bits [5:0] are decoded. Addresses that differ only in bits above bit 5 reach the same register.
- R2: A write to offset 0x00 with any size raises `halt_req` for exactly one cycle. That cycle follows the second clock edge after acceptance. During it, `halt_code` equals bits [7:0] of the write data.
- R3: A read of offset 0x04 returns the `req_id` value captured at acceptance, zero-extended to 32 bits.
- R4: A write to offset 0x08 with size 2 or more takes the port number from bits [7:0] and the level from bits [15:8] of the write data. The selected line `irq_out[port]` becomes 1 when the level is nonzero and 0 when it is zero. The change appears after the second edge following acceptance.
- R5: A write to offset 0x08 with size 1 (or 0) drives the selected port with level 0.
- R6: Each `irq_out` line holds its last driven value until an interrupt write selects it again.
- R7: A read of offset 0x0C returns CPU_COUNT, or 1 when CPU_COUNT is 0 (not configured).
- R8: Every read returns a full 32-bit word with unused bits zero. Any offset other than 0x04 and 0x0C reads as 0.
- R9: Writes to offsets other than 0x00 and 0x08 are accepted and have no effect: no halt and no interrupt change.
- R10: An interrupt write whose port number is N_CPU or larger changes no `irq_out` line.
- R11: A request is accepted only while `bus_ready` is high. `bus_ready` falls for one cycle after acceptance, and `bus_rvalid` pulses for one cycle only after an accepted read.
- R12: After reset, `bus_ready` is 1, and `irq_out`, `halt_req`, `halt_code`, `bus_rvalid` and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits [5:0] are decoded |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data, least significant byte first in use |
| req_id | input | IDW | Index of the requesting processor |
| bus_ready | output | 1 | Block can accept a request this cycle |
| bus_rvalid | output | 1 | Read data valid pulse |
| bus_rdata | output | 32 | Read data |
| halt_req | output | 1 | One-cycle halt request |
| halt_code | output | 8 | Exit status that goes with the halt request |
| irq_out | output | N_CPU | Level interrupt line for each processor |

## Verification
The bench builds two instances with N_CPU=4. The main instance has CPU_COUNT=3 and the second has CPU_COUNT=0, so both the configured and the unconfigured count are read back. With four ports, the sweep of port numbers 0 to 9 and 255 reaches every valid line as well as the out-of-range ports. Crossing those ports with access sizes 1, 2 and 4 and with zero and nonzero levels covers both the hold behaviour and the forced-zero behaviour of one-byte writes. All 64 offsets are read at several alias bases and with every requester ID.

// File: rtl/glue_pkg.sv
package glue_pkg;
    localparam int DEC_BITS = 6;
    localparam int DATA_W   = 32;

    localparam logic [DEC_BITS-1:0] OFF_HALT   = 6'h00;
    localparam logic [DEC_BITS-1:0] OFF_CPUID  = 6'h04;
    localparam logic [DEC_BITS-1:0] OFF_IRQ    = 6'h08;
    localparam logic [DEC_BITS-1:0] OFF_CPUCNT = 6'h0C;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } glue_state_e;

    typedef enum logic [2:0] {
        TGT_HALT   = 3'd0,
        TGT_CPUID  = 3'd1,
        TGT_IRQ    = 3'd2,
        TGT_CPUCNT = 3'd3,
        TGT_NONE   = 3'd4
    } glue_tgt_e;
endpackage

// File: rtl/glue_decode.sv
module glue_decode
    import glue_pkg::*;
(
    input  logic [DEC_BITS-1:0] offset,
    output glue_tgt_e           target
);
    always_comb begin
        unique case (offset)
            OFF_HALT:   target = TGT_HALT;
            OFF_CPUID:  target = TGT_CPUID;
            OFF_IRQ:    target = TGT_IRQ;
            OFF_CPUCNT: target = TGT_CPUCNT;
            default:    target = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/glue_irq_bank.sv
module glue_irq_bank #(
    parameter int N_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd,
    input  logic [7:0]         port_sel,
    input  logic               level,
    output logic [N_PORTS-1:0] lines
);
    for (genvar i = 0; i < N_PORTS; i++) begin : g_line
        logic hit;
        assign hit = upd && (port_sel == 8'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lines[i] <= 1'b0;
            end else if (hit) begin
                lines[i] <= level;
            end
        end
    end
endmodule

// File: rtl/glue_ctrl.sv
module glue_ctrl
    import glue_pkg::*;
#(
    parameter int N_CPU     = 4,
    parameter int CPU_COUNT = 0,
    parameter int IDW       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [DEC_BITS-1:0] req_off,
    input  logic [2:0]          req_size,
    input  logic [15:0]         req_data,
    input  logic [IDW-1:0]      req_id,
    input  glue_tgt_e           cap_tgt,
    output logic [DEC_BITS-1:0] cap_off,
    output logic                ready,
    output logic                rvalid,
    output logic [DATA_W-1:0]   rdata,
    output logic                halt_pulse,
    output logic [7:0]          halt_val,
    output logic                irq_upd,
    output logic [7:0]          irq_port,
    output logic                irq_level
);
    localparam int CNT_VAL = (CPU_COUNT == 0) ? 1 : CPU_COUNT;

    glue_state_e state_q, state_d;
    logic [2:0]     size_q;
    logic [15:0]    data_q;
    logic [IDW-1:0] id_q;
    logic           accept;
    logic [DATA_W-1:0] rd_word;

    assign ready  = (state_q == ST_IDLE);
    assign accept = ready && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = req_write ? ST_WRITE : ST_READ;
            ST_READ:  state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_off <= '0;
            size_q  <= '0;
            data_q  <= '0;
            id_q    <= '0;
        end else if (accept) begin
            cap_off <= req_off;
            size_q  <= req_size;
            data_q  <= req_data;
            id_q    <= req_id;
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (cap_tgt)
            TGT_CPUID:  rd_word = DATA_W'(id_q);
            TGT_CPUCNT: rd_word = DATA_W'(CNT_VAL);
            default:    rd_word = '0;
        endcase
    end

    assign irq_upd   = (state_q == ST_WRITE) && (cap_tgt == TGT_IRQ);
    assign irq_port  = data_q[7:0];
    assign irq_level = (size_q >= 3'd2) && (data_q[15:8] != 8'h00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid     <= 1'b0;
            rdata      <= '0;
            halt_pulse <= 1'b0;
            halt_val   <= '0;
        end else begin
            rvalid     <= (state_q == ST_READ);
            halt_pulse <= (state_q == ST_WRITE) && (cap_tgt == TGT_HALT);
            if (state_q == ST_READ) rdata <= rd_word;
            if ((state_q == ST_WRITE) && (cap_tgt == TGT_HALT)) halt_val <= data_q[7:0];
        end
    end
endmodule

// File: rtl/glue_fw_regs.sv
module glue_fw_regs
    import glue_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int N_CPU     = 4,
    parameter int CPU_COUNT = 0,
    localparam int IDW      = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    input  logic [IDW-1:0]    req_id,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              halt_req,
    output logic [7:0]        halt_code,
    output logic [N_CPU-1:0]  irq_out
);
    logic [DEC_BITS-1:0] cap_off;
    glue_tgt_e           cap_tgt;
    logic                irq_upd;
    logic [7:0]          irq_port;
    logic                irq_level;

    glue_decode u_decode (
        .offset (cap_off),
        .target (cap_tgt)
    );

    glue_ctrl #(
        .N_CPU     (N_CPU),
        .CPU_COUNT (CPU_COUNT),
        .IDW       (IDW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (bus_valid),
        .req_write  (bus_write),
        .req_off    (bus_addr[DEC_BITS-1:0]),
        .req_size   (bus_size),
        .req_data   (bus_wdata[15:0]),
        .req_id     (req_id),
        .cap_tgt    (cap_tgt),
        .cap_off    (cap_off),
        .ready      (bus_ready),
        .rvalid     (bus_rvalid),
        .rdata      (bus_rdata),
        .halt_pulse (halt_req),
        .halt_val   (halt_code),
        .irq_upd    (irq_upd),
        .irq_port   (irq_port),
        .irq_level  (irq_level)
    );

    glue_irq_bank #(.N_PORTS(N_CPU)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (irq_upd),
        .port_sel (irq_port),
        .level    (irq_level),
        .lines    (irq_out)
    );
endmodule

// File: rtl/glue_fw_regs_chk.sv
module glue_fw_regs_chk #(
    parameter int N_CPU = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic             bus_ready,
    input logic             bus_rvalid,
    input logic             halt_req,
    input logic [N_CPU-1:0] irq_out
);
    p_halt_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !halt_req);

    p_halt_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(bus_valid && bus_ready && bus_write, 2));

    p_ready_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready) |=> !bus_ready);

    p_rvalid_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_valid && bus_ready && !bus_write, 2));

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_out) |-> $past(bus_valid && bus_ready && bus_write, 2));

    p_one_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out ^ $past(irq_out)) <= 1);
endmodule

bind glue_fw_regs glue_fw_regs_chk #(.N_CPU(N_CPU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_ready  (bus_ready),
    .bus_rvalid (bus_rvalid),
    .halt_req   (halt_req),
    .irq_out    (irq_out)
);

// File: tb/glue_fw_regs_tb.sv
module glue_fw_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int CNT  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  req_id = '0;
    logic        bus_ready, bus_rvalid, halt_req;
    logic [31:0] bus_rdata;
    logic [7:0]  halt_code;
    logic [NCPU-1:0] irq_out;
    logic        ready2, rvalid2, halt2;
    logic [31:0] rdata2;
    logic [7:0]  code2;
    logic [NCPU-1:0] irq2;

    int errors = 0;
    int checks = 0;
    logic [NCPU-1:0] exp_irq = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    glue_fw_regs #(.ADDR_W(32), .N_CPU(NCPU), .CPU_COUNT(CNT)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .req_id(req_id), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .halt_req(halt_req), .halt_code(halt_code),
        .irq_out(irq_out));

    glue_fw_regs #(.ADDR_W(32), .N_CPU(NCPU), .CPU_COUNT(0)) u_dut_nocnt (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .req_id(req_id), .bus_ready(ready2), .bus_rvalid(rvalid2),
        .bus_rdata(rdata2), .halt_req(halt2), .halt_code(code2),
        .irq_out(irq2));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, accept on the next rising edge,
    // effect on the following rising edge, sample at the falling edge after it.
    task automatic access(input logic wr, input logic [31:0] addr, input logic [2:0] size,
                          input logic [31:0] data, input logic [1:0] id);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr;
        bus_size = size; bus_wdata = data; req_id = id;
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = '1; bus_wdata = '1; req_id = ~id;
        check("R11 ready low in access phase", 32'(bus_ready), 32'd0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [7:0] lv [4] = '{8'h00, 8'h01, 8'h5A, 8'h00};
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 ready", 32'(bus_ready), 32'd1);
        check("R12 irq", 32'(irq_out), 32'd0);
        check("R12 halt", 32'(halt_req), 32'd0);
        check("R12 code", 32'(halt_code), 32'd0);
        check("R12 rvalid", 32'(bus_rvalid), 32'd0);
        check("R12 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R10 R6 R1: interrupt sweep, aliased bases
        for (int p = 0; p < 11; p++) begin
            for (int s = 0; s < 3; s++) begin
                for (int l = 0; l < 4; l++) begin
                    logic [7:0] port;
                    logic [2:0] sz;
                    port = (p == 10) ? 8'd255 : 8'(p);
                    sz = (s == 0) ? 3'd1 : ((s == 1) ? 3'd2 : 3'd4);
                    access(1'b1, 32'h08 | (32'(p + l) << 6), sz,
                           {16'hFFFF, lv[l], port}, 2'd0);
                    if (port < NCPU) exp_irq[port] = (sz >= 3'd2) && (lv[l] != 8'h00);
                    if (port >= NCPU)
                        check("R10 out-of-range port", 32'(irq_out), 32'(exp_irq));
                    else if (sz == 3'd1)
                        check("R5 one-byte level zero", 32'(irq_out), 32'(exp_irq));
                    else
                        check("R4 R6 irq level", 32'(irq_out), 32'(exp_irq));
                    check("R9 no halt on irq write", 32'(halt_req), 32'd0);
                    check("R11 no rvalid on write", 32'(bus_rvalid), 32'd0);
                end
            end
        end
        // leave a known pattern: ports 1 and 3 high
        access(1'b1, 32'h08, 3'd2, 32'h0000_0101, 2'd0); exp_irq[1] = 1'b1;
        access(1'b1, 32'h48, 3'd2, 32'h0000_0803, 2'd0); exp_irq[3] = 1'b1;
        check("R4 pattern", 32'(irq_out), 32'(exp_irq));

        // R3 R7 R8 R1: read every offset, every requester, alias bases
        for (int base = 0; base < 3; base++) begin
            for (int off = 0; off < 64; off++) begin
                for (int id = 0; id < 4; id++) begin
                    logic [31:0] expv;
                    expv = (off == 4) ? 32'(id) : ((off == 12) ? 32'(CNT) : 32'd0);
                    access(1'b0, 32'(off) | (32'(base) * 32'h1000_0040), 3'd4, 32'h0, 2'(id));
                    check("R11 rvalid on read", 32'(bus_rvalid), 32'd1);
                    if (off == 4) check("R3 cpu index", bus_rdata, expv);
                    else if (off == 12) check("R7 cpu count", bus_rdata, expv);
                    else check("R8 zero read", bus_rdata, expv);
                    check("R6 irq held during reads", 32'(irq_out), 32'(exp_irq));
                end
            end
        end
        access(1'b0, 32'h0C, 3'd1, 32'h0, 2'd0);
        check("R7 unconfigured count", rdata2, 32'd1);
        check("R7 configured count", bus_rdata, 32'(CNT));
        @(negedge clk);
        check("R11 rvalid one cycle", 32'(bus_rvalid), 32'd0);

        // R9: writes to read-only/unmapped offsets
        for (int off = 1; off < 64; off++) begin
            if (off != 8) begin
                access(1'b1, 32'(off), 3'd4, 32'hFFFF_FF00, 2'd0);
                check("R9 ignored write irq", 32'(irq_out), 32'(exp_irq));
                check("R9 ignored write halt", 32'(halt_req), 32'd0);
            end
        end

        // R2 halt with codes, aliases, sizes
        for (int h = 0; h < 4; h++) begin
            logic [7:0] code;
            code = 8'(h * 8'h55 + 8'h0F);
            access(1'b1, 32'(h) << 6, 3'(h + 1), {24'hABCDEF, code}, 2'd1);
            check("R2 halt pulse", 32'(halt_req), 32'd1);
            check("R2 halt code", 32'(halt_code), 32'(code));
            check("R6 irq unaffected by halt", 32'(irq_out), 32'(exp_irq));
            @(negedge clk);
            check("R2 halt single cycle", 32'(halt_req), 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule